// File: doc/BRIEF.md
# Channel Bus Command Queue

This block sits between a host register interface and the transmitter of one serial-bus channel. The host pushes bus commands into a four-slot ring. Each entry holds the command word, a transfer kind and the channel's word format. The ring offers the oldest entry to the transmitter over a valid/ready handshake. An entry leaves the ring only when the transmitter accepts it, which it does once the bus is free.

Each response the bus returns is placed in a response ring of the same depth. The host reads responses back oldest first. A command is offered only when the response ring has room for its reply, counting replies still in flight. A host write that finds the command ring full is dropped and sets a sticky overflow flag. A status read clears that flag.

Top module: `chan_cmd_queue`

## Requirements
- R1: The command ring holds up to DEPTH (default 4) entries. `cmdCount` gives the number held, `cmdEmpty` is high at zero entries and `cmdFull` is high at DEPTH entries.
- R2: Commands are offered on `txCmd` in the order the host wrote them. `txValid` is high while an entry is held and the response gate allows it. An entry is removed only in a cycle where `txValid` and `txReady` are both high.
- R3: While `txValid` is high and `txReady` is low, `txValid` stays high and the offered command does not change.
- R4: Each entry keeps the kind given at write time on `txKind`. Kinds 2 and 3 (top kind bit set) are addressable-FIFO transfers. For these, `txLong` carries the `longWord` value sampled at write time: 1 means long words, 0 means enhanced short words. For kinds 0 and 1, `txLong` is 0.
- R5: A host write while `cmdFull` is high is dropped and leaves the ring contents unchanged. `overflow` reads 1 from the next cycle.
- R6: No new command is offered while responses held plus commands in flight equal DEPTH. Offering resumes the cycle after a host read frees a slot.
- R7: Responses are returned in arrival order. `hostRdData` shows the oldest response and `hostRdReq` removes it. `rspCount`, `rspEmpty` and `rspFull` give the fill of the response ring.
- R8: `statusRd` clears `overflow` on the next cycle, unless a write is dropped in the same cycle.
- R9: After reset both rings are empty, both counts read 0, and `txValid` and `overflow` are 0.
- R10: A `hostRdReq` while the response ring is empty is ignored. A `rspValid` while no command is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrValid | input | 1 | Host pushes a command |
| hostWrCmd | input | CMD_W | Command word to push |
| hostWrKind | input | KIND_W | Transfer kind of the pushed command |
| longWord | input | 1 | Channel word format, 1 = long words |
| statusRd | input | 1 | Host status read, clears overflow |
| txValid | output | 1 | Command offered to the transmitter |
| txReady | input | 1 | Transmitter accepts the offered command |
| txCmd | output | CMD_W | Offered command word |
| txKind | output | KIND_W | Offered transfer kind |
| txLong | output | 1 | Offered word format |
| rspValid | input | 1 | Bus transfer done, response present |
| rspData | input | RSP_W | Response word from the bus |
| hostRdReq | input | 1 | Host takes the oldest response |
| hostRdData | output | RSP_W | Oldest held response |
| cmdFull | output | 1 | Command ring full |
| cmdEmpty | output | 1 | Command ring empty |
| cmdCount | output | CNT_W | Command entries held |
| rspFull | output | 1 | Response ring full |
| rspEmpty | output | 1 | Response ring empty |
| rspCount | output | CNT_W | Responses held |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A read or write pointer that slips shows at the ports within one handshake. The transmitter then sees a command out of order, or the host reads a reply from the wrong slot. A wrong in-flight count has two symptoms. A reply can be lost, so the host reads fewer responses than were sent. Or issue stays blocked after a host read, which `txValid` shows on the cycle after that read. A count or flag error shows at once on the registered status outputs, on the cycle after the stimulus.

// File: rtl/chan_cmd_queue_pkg.sv
package chan_cmd_queue_pkg;
  // strobes from control to datapath, one per ring operation
  typedef struct packed {
    logic cmdPush;
    logic cmdPop;
    logic rspPush;
    logic rspPop;
  } qStrobe_t;
endpackage

// File: rtl/chan_cmd_queue_ctrl.sv
module chan_cmd_queue_ctrl
  import chan_cmd_queue_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrValid,
  input  logic             txReady,
  input  logic             rspValid,
  input  logic             hostRdReq,
  input  logic             statusRd,
  output qStrobe_t         strb,
  output logic [PTR_W-1:0] cmdWrPtr,
  output logic [PTR_W-1:0] cmdRdPtr,
  output logic [PTR_W-1:0] rspWrPtr,
  output logic [PTR_W-1:0] rspRdPtr,
  output logic             txValid,
  output logic             cmdFull,
  output logic             cmdEmpty,
  output logic [CNT_W-1:0] cmdCount,
  output logic             rspFull,
  output logic             rspEmpty,
  output logic [CNT_W-1:0] rspCount,
  output logic             overflow
);
  localparam logic [CNT_W:0] DEPTH_S = (CNT_W + 1)'(DEPTH);

  logic [CNT_W-1:0] inFlight;
  logic             gateOpen;
  logic             dropWr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cmdFull  = (cmdCount == CNT_W'(DEPTH));
  assign cmdEmpty = (cmdCount == '0);
  assign rspFull  = (rspCount == CNT_W'(DEPTH));
  assign rspEmpty = (rspCount == '0);

  // a reply slot must be free for every command on the bus
  assign gateOpen = ({1'b0, rspCount} + {1'b0, inFlight}) < DEPTH_S;
  assign txValid  = !cmdEmpty && gateOpen;
  assign dropWr   = hostWrValid && cmdFull;

  always_comb begin
    strb.cmdPush = hostWrValid && !cmdFull;
    strb.cmdPop  = txValid && txReady;
    strb.rspPush = rspValid && (inFlight != '0);
    strb.rspPop  = hostRdReq && !rspEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWrPtr <= '0;
      cmdRdPtr <= '0;
      rspWrPtr <= '0;
      rspRdPtr <= '0;
      cmdCount <= '0;
      rspCount <= '0;
      inFlight <= '0;
      overflow <= 1'b0;
    end else begin
      if (strb.cmdPush) cmdWrPtr <= bump(cmdWrPtr);
      if (strb.cmdPop)  cmdRdPtr <= bump(cmdRdPtr);
      if (strb.rspPush) rspWrPtr <= bump(rspWrPtr);
      if (strb.rspPop)  rspRdPtr <= bump(rspRdPtr);
      cmdCount <= cmdCount + CNT_W'(strb.cmdPush) - CNT_W'(strb.cmdPop);
      rspCount <= rspCount + CNT_W'(strb.rspPush) - CNT_W'(strb.rspPop);
      inFlight <= inFlight + CNT_W'(strb.cmdPop) - CNT_W'(strb.rspPush);
      if (dropWr)        overflow <= 1'b1;
      else if (statusRd) overflow <= 1'b0;
    end
  end

  AST_CMD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cmdCount <= CNT_W'(DEPTH)); // R1
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(cmdRdPtr))); // R3
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrValid && cmdFull) |=> overflow); // R5
  AST_RSP_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && inFlight != '0) |-> !rspFull); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !(hostWrValid && cmdFull)) |=> !overflow); // R8
endmodule

// File: rtl/chan_cmd_queue_dpath.sv
module chan_cmd_queue_dpath
  import chan_cmd_queue_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CMD_W  = 16,
  parameter int KIND_W = 2,
  parameter int RSP_W  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strb,
  input  logic [PTR_W-1:0]  cmdWrPtr,
  input  logic [PTR_W-1:0]  cmdRdPtr,
  input  logic [PTR_W-1:0]  rspWrPtr,
  input  logic [PTR_W-1:0]  rspRdPtr,
  input  logic [CMD_W-1:0]  hostWrCmd,
  input  logic [KIND_W-1:0] hostWrKind,
  input  logic              longWord,
  input  logic [RSP_W-1:0]  rspData,
  output logic [CMD_W-1:0]  txCmd,
  output logic [KIND_W-1:0] txKind,
  output logic              txLong,
  output logic [RSP_W-1:0]  hostRdData
);
  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [KIND_W-1:0] kind;
    logic              isLong;
  } cmdEntry_t;

  cmdEntry_t        cmdMem [DEPTH];
  logic [RSP_W-1:0] rspMem [DEPTH];
  cmdEntry_t        newEntry;

  // the word format only matters for FIFO kinds (top kind bit set)
  always_comb begin
    newEntry.cmd    = hostWrCmd;
    newEntry.kind   = hostWrKind;
    newEntry.isLong = hostWrKind[KIND_W-1] & longWord;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdMem[s] <= '0;
        rspMem[s] <= '0;
      end else begin
        if (strb.cmdPush && cmdWrPtr == PTR_W'(s)) cmdMem[s] <= newEntry;
        if (strb.rspPush && rspWrPtr == PTR_W'(s)) rspMem[s] <= rspData;
      end
    end
  end

  assign txCmd      = cmdMem[cmdRdPtr].cmd;
  assign txKind     = cmdMem[cmdRdPtr].kind;
  assign txLong     = cmdMem[cmdRdPtr].isLong;
  assign hostRdData = rspMem[rspRdPtr];

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cmdPop && !strb.cmdPush) |=> $stable(txCmd)); // R3
  AST_RSP_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rspPop && !strb.rspPush) |=> $stable(hostRdData)); // R7
endmodule

// File: rtl/chan_cmd_queue.sv
module chan_cmd_queue
  import chan_cmd_queue_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CMD_W  = 16,
  parameter int KIND_W = 2,
  parameter int RSP_W  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrValid,
  input  logic [CMD_W-1:0]  hostWrCmd,
  input  logic [KIND_W-1:0] hostWrKind,
  input  logic              longWord,
  input  logic              statusRd,
  output logic              txValid,
  input  logic              txReady,
  output logic [CMD_W-1:0]  txCmd,
  output logic [KIND_W-1:0] txKind,
  output logic              txLong,
  input  logic              rspValid,
  input  logic [RSP_W-1:0]  rspData,
  input  logic              hostRdReq,
  output logic [RSP_W-1:0]  hostRdData,
  output logic              cmdFull,
  output logic              cmdEmpty,
  output logic [CNT_W-1:0]  cmdCount,
  output logic              rspFull,
  output logic              rspEmpty,
  output logic [CNT_W-1:0]  rspCount,
  output logic              overflow
);
  qStrobe_t         strb;
  logic [PTR_W-1:0] cmdWrPtr, cmdRdPtr, rspWrPtr, rspRdPtr;

  chan_cmd_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrValid(hostWrValid), .txReady(txReady),
    .rspValid(rspValid), .hostRdReq(hostRdReq), .statusRd(statusRd),
    .strb(strb), .cmdWrPtr(cmdWrPtr), .cmdRdPtr(cmdRdPtr),
    .rspWrPtr(rspWrPtr), .rspRdPtr(rspRdPtr), .txValid(txValid),
    .cmdFull(cmdFull), .cmdEmpty(cmdEmpty), .cmdCount(cmdCount),
    .rspFull(rspFull), .rspEmpty(rspEmpty), .rspCount(rspCount),
    .overflow(overflow)
  );

  chan_cmd_queue_dpath #(
    .DEPTH(DEPTH), .CMD_W(CMD_W), .KIND_W(KIND_W), .RSP_W(RSP_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWrPtr(cmdWrPtr),
    .cmdRdPtr(cmdRdPtr), .rspWrPtr(rspWrPtr), .rspRdPtr(rspRdPtr),
    .hostWrCmd(hostWrCmd), .hostWrKind(hostWrKind), .longWord(longWord),
    .rspData(rspData), .txCmd(txCmd), .txKind(txKind), .txLong(txLong),
    .hostRdData(hostRdData)
  );
endmodule

// File: tb/chan_cmd_queue_tb.sv
module chan_cmd_queue_tb;
  localparam int CNT_W = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrValid = 1'b0;
  logic [15:0] hostWrCmd = '0;
  logic [1:0]  hostWrKind = '0;
  logic        longWord = 1'b0;
  logic        statusRd = 1'b0;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [15:0] txCmd;
  logic [1:0]  txKind;
  logic        txLong;
  logic        rspValid = 1'b0;
  logic [15:0] rspData = '0;
  logic        hostRdReq = 1'b0;
  logic [15:0] hostRdData;
  logic        cmdFull, cmdEmpty, rspFull, rspEmpty, overflow;
  logic [CNT_W-1:0] cmdCount, rspCount;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  chan_cmd_queue u_dut (
    .clk(clk), .rstN(rstN), .hostWrValid(hostWrValid), .hostWrCmd(hostWrCmd),
    .hostWrKind(hostWrKind), .longWord(longWord), .statusRd(statusRd),
    .txValid(txValid), .txReady(txReady), .txCmd(txCmd), .txKind(txKind),
    .txLong(txLong), .rspValid(rspValid), .rspData(rspData),
    .hostRdReq(hostRdReq), .hostRdData(hostRdData), .cmdFull(cmdFull),
    .cmdEmpty(cmdEmpty), .cmdCount(cmdCount), .rspFull(rspFull),
    .rspEmpty(rspEmpty), .rspCount(rspCount), .overflow(overflow)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct packed {
    logic [15:0] cmd;
    logic [1:0]  kind;
    logic        lw;
    logic        expLong;
    logic [15:0] rsp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{cmd: 16'h1111, kind: 2'd0, lw: 1'b1, expLong: 1'b0, rsp: 16'hA001},
    '{cmd: 16'h2222, kind: 2'd1, lw: 1'b1, expLong: 1'b0, rsp: 16'hA002},
    '{cmd: 16'h3333, kind: 2'd2, lw: 1'b1, expLong: 1'b1, rsp: 16'hA003},
    '{cmd: 16'h4444, kind: 2'd2, lw: 1'b0, expLong: 1'b0, rsp: 16'hA004},
    '{cmd: 16'h5555, kind: 2'd3, lw: 1'b1, expLong: 1'b1, rsp: 16'hA005},
    '{cmd: 16'h6666, kind: 2'd3, lw: 1'b0, expLong: 1'b0, rsp: 16'hA006}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] c, input logic [1:0] k, input logic lw);
    @(negedge clk);
    hostWrValid = 1'b1; hostWrCmd = c; hostWrKind = k; longWord = lw;
    @(negedge clk);
    hostWrValid = 1'b0; longWord = 1'b0;
  endtask

  task automatic doAccept();
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
  endtask

  task automatic doRsp(input logic [15:0] d);
    @(negedge clk); rspValid = 1'b1; rspData = d;
    @(negedge clk); rspValid = 1'b0;
  endtask

  task automatic doRead();
    @(negedge clk); hostRdReq = 1'b1;
    @(negedge clk); hostRdReq = 1'b0;
  endtask

  task automatic doStatus();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] burst [4];
    logic [15:0] replies [4];
    burst   = '{16'h0B01, 16'h0B02, 16'h0B03, 16'h0B04};
    replies = '{16'hC001, 16'hC002, 16'hC003, 16'hC004};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 cmdEmpty", cmdEmpty, 1);
    check("R9 rspEmpty", rspEmpty, 1);
    check("R9 cmdCount", cmdCount, 0);
    check("R9 txValid", txValid, 0);
    check("R9 overflow", overflow, 0);

    // R10 ignored stimulus
    doRead();
    check("R10 read empty count", rspCount, 0);
    doRsp(16'hDEAD);
    check("R10 stray rsp count", rspCount, 0);
    check("R10 stray rsp empty", rspEmpty, 1);

    // table walk: R2 R4 R7
    for (int i = 0; i < 6; i++) begin
      doWrite(VECS[i].cmd, VECS[i].kind, VECS[i].lw);
      check("R2 txValid", txValid, 1);
      check("R2 txCmd", txCmd, VECS[i].cmd);
      check("R4 txKind", txKind, VECS[i].kind);
      check("R4 txLong", txLong, VECS[i].expLong);
      doAccept();
      check("R2 popped", cmdEmpty, 1);
      doRsp(VECS[i].rsp);
      check("R7 rspCount", rspCount, 1);
      check("R7 hostRdData", hostRdData, VECS[i].rsp);
      doRead();
      check("R7 rspEmpty", rspEmpty, 1);
    end

    // R1 fill, R3 hold, R5 drop
    for (int i = 0; i < 4; i++) doWrite(burst[i], 2'd0, 1'b0);
    check("R1 cmdFull", cmdFull, 1);
    check("R1 cmdCount", cmdCount, 4);
    @(negedge clk);
    check("R3 held valid", txValid, 1);
    check("R3 held cmd", txCmd, burst[0]);
    doWrite(16'hEEEE, 2'd1, 1'b0);
    check("R5 overflow", overflow, 1);
    check("R5 count kept", cmdCount, 4);
    doStatus();
    check("R8 cleared", overflow, 0);

    for (int i = 0; i < 4; i++) begin
      check("R2 order", txCmd, burst[i]);
      doAccept();
    end
    check("R5 dropped not issued", cmdEmpty, 1);

    for (int i = 0; i < 4; i++) doRsp(replies[i]);
    check("R7 rspFull", rspFull, 1);

    // R6 gate
    doWrite(16'h7777, 2'd0, 1'b0);
    check("R6 gated", txValid, 0);
    check("R6 queued", cmdCount, 1);
    check("R7 oldest", hostRdData, replies[0]);
    doRead();
    check("R6 resumed", txValid, 1);
    check("R6 cmd", txCmd, 16'h7777);
    for (int i = 1; i < 4; i++) begin
      check("R7 order", hostRdData, replies[i]);
      doRead();
    end
    check("R7 drained", rspEmpty, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule